// File: doc/BRIEF.md
# Zero-Skipping Feature/Weight Pair Scheduler

This block sits in front of a multiplier array and removes useless work from its input stream. Each input beat carries a feature vector of 16 channel elements, the weight vector that multiplies it, and a flag that marks the final beat of an accumulation group. A feature vector whose elements are all zero would add nothing to the dot product. The scheduler consumes such a beat in a single cycle, drops its weight vector with it, and forwards nothing. Every other pair is forwarded intact, one pair per output beat. A group of N pairs that holds Z all-zero feature vectors therefore costs the multiplier array N - Z beats.

The downstream accumulator closes an output on the group-end flag, so that flag must survive skipping. The scheduler keeps the most recent non-zero pair in a one-entry holding stage until it knows whether another non-zero pair follows in the same group. When the group ends on a skipped pair, the flag moves onto the held pair. When every pair of a group is zero, the scheduler emits one zero-valued pair that carries both the flag and a null marker, so the output is still produced. A saturating counter reports how many pairs have been skipped since reset.

Top module: `zs_sched`

## Requirements
- R1: A pair whose feature vector is zero in all 16 lanes (lane k occupies bits [8k+7:8k] of `in_fm`) is never forwarded as a data pair. Any single non-zero lane makes a pair non-zero.
- R2: Each forwarded pair carries the weight vector that arrived with its feature vector, and forwarded pairs keep their input order.
- R3: While `out_valid` is high and `out_ready` is low, `out_fm`, `out_wt`, `out_last` and `out_null` hold steady. Each accepted output beat carries exactly one pair.
- R4: Over a group of N pairs with Z zero feature vectors, exactly N - Z output beats are produced when Z < N. With `out_ready` held high, the N input beats are accepted on N consecutive clock edges.
- R5: The last forwarded pair of a group has `out_last` = 1 and all earlier pairs have `out_last` = 0, even when the group's final input pair was skipped.
- R6: A group made only of zero feature vectors yields exactly one beat with `out_null` = 1, `out_last` = 1 and `out_fm` = `out_wt` = 0. `out_null` is 0 on every other beat.
- R7: A zero pair that is not the end of its group is accepted in the cycle it is offered, even while the output is stalled, and it does not load the output.
- R8: `skip_count` is 0 after reset, rises by one for each accepted zero pair, and saturates at its maximum.
- R9: During reset and in the first cycle after it, `out_valid` is 0.
- R10: A held non-zero pair appears on the output in the cycle after the clock edge that accepts the next non-zero pair or the group's closing pair. A non-zero group-end pair that arrives with the holding stage empty appears in the cycle after its own acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Input pair accepted on this edge if valid |
| in_fm | input | 128 | Feature vector, 16 lanes of 8 bits |
| in_wt | input | 128 | Weight vector, 16 lanes of 8 bits |
| in_last | input | 1 | Pair closes its accumulation group |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Multiplier array takes the pair |
| out_fm | output | 128 | Forwarded feature vector |
| out_wt | output | 128 | Forwarded weight vector |
| out_last | output | 1 | Forwarded pair closes its group |
| out_null | output | 1 | Zero-contribution filler beat for an all-zero group |
| skip_count | output | 16 | Saturating count of skipped pairs |

## Verification
Because of the holding stage, a non-zero pair reaches the output one cycle after the acceptance edge of the next non-zero or closing pair, not after its own. A closing non-zero pair that finds the holding stage full appears two cycles after its acceptance. The bench drives each input beat at the falling edge and reads `in_ready` just before the rising edge, so it knows the exact acceptance edge. It then checks the directed latency cases at the falling edge that follows. The scoreboard builds its expected pairs from the skip mask before it sends a group, and it compares each beat in the half-cycle before the edge that transfers it. It also counts output beats against N - Z and input cycles against N.

// File: rtl/zs_pkg.sv
package zs_pkg;
  // Classification of an offered input pair.
  typedef enum logic [1:0] {
    KIND_NZ_MID   = 2'd0,
    KIND_ZERO_MID = 2'd1,
    KIND_ZERO_END = 2'd2,
    KIND_NZ_END   = 2'd3
  } zs_kind_e;

  // Source selected when the output register loads.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_IN   = 2'd1,
    SRC_NULL = 2'd2
  } zs_src_e;
endpackage

// File: rtl/zs_zero_detect.sv
module zs_zero_detect #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 8
) (
  input  logic [LANES*ELEM_W-1:0] vec,
  output logic                    all_zero
);
  logic [LANES-1:0] lane_nz;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_nz[g] = |vec[g*ELEM_W +: ELEM_W];
  end

  assign all_zero = ~|lane_nz;
endmodule

// File: rtl/zs_skip_counter.sv
module zs_skip_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/zs_sched.sv
module zs_sched
  import zs_pkg::*;
#(
  parameter int LANES = 16,
  parameter int FM_W  = 8,
  parameter int WT_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*FM_W-1:0] in_fm,
  input  logic [LANES*WT_W-1:0] in_wt,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*FM_W-1:0] out_fm,
  output logic [LANES*WT_W-1:0] out_wt,
  output logic                  out_last,
  output logic                  out_null,
  output logic [CNT_W-1:0]      skip_count
);
  localparam int FV_W = LANES * FM_W;
  localparam int WV_W = LANES * WT_W;

  // Holding stage: last non-zero pair whose group-end status is unknown.
  logic            hold_v_q, hold_v_d, hold_fin_q, hold_fin_d, hold_ld;
  logic [FV_W-1:0] hold_fm_q;
  logic [WV_W-1:0] hold_wt_q;
  // Output register.
  logic            out_v_q, out_v_d, out_ld, out_last_d, out_null_d;
  logic            out_last_q, out_null_q;
  zs_src_e         out_src;
  logic [FV_W-1:0] out_fm_q, out_fm_d;
  logic [WV_W-1:0] out_wt_q, out_wt_d;

  logic            all_zero, out_free, fire;
  zs_kind_e        kind;

  zs_zero_detect #(.LANES(LANES), .ELEM_W(FM_W)) zdet_i (
    .vec      (in_fm),
    .all_zero (all_zero)
  );

  zs_skip_counter #(.CNT_W(CNT_W)) scnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fire && all_zero),
    .count (skip_count)
  );

  // Acceptance decision.
  always_comb begin
    if (all_zero) kind = in_last ? KIND_ZERO_END : KIND_ZERO_MID;
    else          kind = in_last ? KIND_NZ_END   : KIND_NZ_MID;
    out_free = !out_v_q || out_ready;
    if (hold_fin_q) in_ready = 1'b0;
    else begin
      unique case (kind)
        KIND_ZERO_MID: in_ready = 1'b1;
        KIND_NZ_MID:   in_ready = !hold_v_q || out_free;
        default:       in_ready = out_free;
      endcase
    end
    fire = in_valid && in_ready;
  end

  // Next-state logic.
  always_comb begin
    hold_v_d   = hold_v_q;
    hold_fin_d = hold_fin_q;
    hold_ld    = 1'b0;
    out_v_d    = out_v_q && !out_ready;
    out_ld     = 1'b0;
    out_src    = SRC_HOLD;
    out_last_d = 1'b0;
    if (hold_fin_q && out_free) begin
      out_ld     = 1'b1;
      out_last_d = 1'b1;
      hold_v_d   = 1'b0;
      hold_fin_d = 1'b0;
    end else if (fire) begin
      unique case (kind)
        KIND_NZ_MID: begin
          out_ld   = hold_v_q;
          hold_ld  = 1'b1;
          hold_v_d = 1'b1;
        end
        KIND_ZERO_END: begin
          out_ld     = 1'b1;
          out_src    = hold_v_q ? SRC_HOLD : SRC_NULL;
          out_last_d = 1'b1;
          hold_v_d   = 1'b0;
        end
        KIND_NZ_END: begin
          out_ld = 1'b1;
          if (hold_v_q) begin
            hold_ld    = 1'b1;
            hold_fin_d = 1'b1;
          end else begin
            out_src    = SRC_IN;
            out_last_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (out_ld) out_v_d = 1'b1;
    out_null_d = (out_src == SRC_NULL);
    unique case (out_src)
      SRC_IN:   begin out_fm_d = in_fm;     out_wt_d = in_wt;     end
      SRC_NULL: begin out_fm_d = '0;        out_wt_d = '0;        end
      default:  begin out_fm_d = hold_fm_q; out_wt_d = hold_wt_q; end
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q   <= 1'b0;
      hold_fin_q <= 1'b0;
      out_v_q    <= 1'b0;
    end else begin
      hold_v_q   <= hold_v_d;
      hold_fin_q <= hold_fin_d;
      out_v_q    <= out_v_d;
    end
  end

  // Data registers, enabled loads only.
  always_ff @(posedge clk) begin
    if (hold_ld) begin
      hold_fm_q <= in_fm;
      hold_wt_q <= in_wt;
    end
    if (out_ld) begin
      out_fm_q   <= out_fm_d;
      out_wt_q   <= out_wt_d;
      out_last_q <= out_last_d;
      out_null_q <= out_null_d;
    end
  end

  assign out_valid = out_v_q;
  assign out_fm    = out_fm_q;
  assign out_wt    = out_wt_q;
  assign out_last  = out_last_q;
  assign out_null  = out_null_q;

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fm) && $stable(out_wt)
                                && $stable(out_last) && $stable(out_null));
  // R6
  null_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_null |-> out_last && (out_fm == '0) && (out_wt == '0));
  // R1
  no_zero_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_null |-> (out_fm != '0));
  // R7
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (kind == KIND_ZERO_MID) && out_free |=> !out_valid);
  // R9
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/zs_sched_tb_top.sv
module zs_sched_tb_top;
  localparam int LANES = 16;
  localparam int EW    = 8;
  localparam int VW    = LANES * EW;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [VW-1:0] in_fm = '0, in_wt = '0;
  logic          in_ready, out_valid, out_last, out_null;
  logic [VW-1:0] out_fm, out_wt;
  logic [CW-1:0] skip_count;

  typedef struct packed {
    logic [VW-1:0] fm;
    logic [VW-1:0] wt;
    logic          last;
    logic          nul;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, xfer = 0, zeros_sent = 0, ready_mode = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  zs_sched #(.LANES(LANES), .FM_W(EW), .WT_W(EW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fm(in_fm), .in_wt(in_wt), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_fm(out_fm), .out_wt(out_wt),
    .out_last(out_last), .out_null(out_null), .skip_count(skip_count)
  );

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Output ready pattern: 0 always high, 1 random, 2 held low.
  initial forever begin
    @(negedge clk);
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // Monitor: compares just before the edge that transfers the beat.
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      xfer++;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected beat", out_fm, '0);
      else begin
        e = exp_q.pop_front();
        check(out_fm == e.fm, "R1 fm", out_fm, e.fm);
        check(out_wt == e.wt, "R2 wt", out_wt, e.wt);
        check(out_last == e.last, "R5 last", VW'(out_last), VW'(e.last));
        check(out_null == e.nul, "R6 null", VW'(out_null), VW'(e.nul));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  function automatic logic [VW-1:0] rand_nz(input bit sparse);
    logic [VW-1:0] v;
    if (sparse) begin
      v = '0;
      v[($urandom % LANES)*EW +: EW] = EW'(($urandom % 255) + 1);
    end else begin
      v = {$urandom, $urandom, $urandom, $urandom};
      if (v == '0) v[0] = 1'b1;
    end
    return v;
  endfunction

  // Driver: called at a falling edge, returns at the falling edge after acceptance.
  task automatic send_pair(input logic [VW-1:0] f, input logic [VW-1:0] w,
                           input logic l, output int cyc);
    bit acc;
    in_valid = 1'b1; in_fm = f; in_wt = w; in_last = l; cyc = 0;
    do begin
      #1;
      acc = in_ready;
      cyc++;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
    if (f == '0) zeros_sent++;
  endtask

  // Sends a group; bit i of zmask set makes pair i zero. Expected beats are queued first.
  task automatic send_group(input int n, input logic [31:0] zmask, input bit sparse,
                            output int cycles, output logic [VW-1:0] first_fm);
    logic [VW-1:0] fv[32], wv[32];
    int last_nz = -1;
    int c;
    first_fm = '0;
    for (int i = 0; i < n; i++) begin
      wv[i] = {$urandom, $urandom, $urandom, $urandom};
      fv[i] = zmask[i] ? '0 : rand_nz(sparse);
      if (!zmask[i]) last_nz = i;
    end
    for (int i = 0; i < n; i++)
      if (!zmask[i]) begin
        if (first_fm == '0) first_fm = fv[i];
        exp_q.push_back('{fm: fv[i], wt: wv[i], last: (i == last_nz), nul: 1'b0});
      end
    if (last_nz < 0) exp_q.push_back('{fm: '0, wt: '0, last: 1'b1, nul: 1'b1});
    cycles = 0;
    for (int i = 0; i < n; i++) begin
      send_pair(fv[i], wv[i], i == n - 1, c);
      cycles += c;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cyc, x0;
    logic [VW-1:0] ff, f1;
    repeat (3) @(negedge clk);
    // R9 / R8: reset state
    check(!out_valid, "R9 reset valid", VW'(out_valid), '0);
    check(skip_count == '0, "R8 reset count", VW'(skip_count), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9 after reset", VW'(out_valid), '0);

    // R10: single non-zero closing pair, holding stage empty
    ready_mode = 0;
    send_group(1, 32'h0, 1'b0, cyc, ff);
    #1 check(out_valid && out_last && out_fm == ff, "R10 direct close", out_fm, ff);
    drain();

    // R5/R10: non-zero then zero closing pair, flag moves to held pair
    send_group(2, 32'h2, 1'b0, cyc, ff);
    #1 check(out_valid && out_last && !out_null && out_fm == ff, "R5 moved end", out_fm, ff);
    drain();

    // R6: all-zero group
    send_group(4, 32'hF, 1'b0, cyc, ff);
    #1 check(out_valid && out_null && out_last, "R6 null beat", VW'(out_null), VW'(1));
    drain();

    // R4: 8 pairs, 5 zero (last one zero), single-lane features
    x0 = xfer;
    send_group(8, 32'hB6, 1'b1, cyc, ff);
    check(cyc == 8, "R4 input cycles", VW'(cyc), VW'(8));
    drain();
    check(xfer - x0 == 3, "R4 output beats", VW'(xfer - x0), VW'(3));

    // R7: zero pair accepted while output is stalled
    ready_mode = 2;
    @(negedge clk);
    f1 = rand_nz(1'b0);
    ff = rand_nz(1'b1);
    exp_q.push_back('{fm: f1, wt: VW'(1), last: 1'b0, nul: 1'b0});
    exp_q.push_back('{fm: ff, wt: VW'(2), last: 1'b1, nul: 1'b0});
    send_pair(f1, VW'(1), 1'b0, cyc);
    send_pair(ff, VW'(2), 1'b0, cyc);
    send_pair('0, VW'(3), 1'b0, cyc);
    check(cyc == 1, "R7 skip one cycle", VW'(cyc), VW'(1));
    // R3: stalled output holds the first pair
    check(out_valid && out_fm == f1, "R3 stall hold", out_fm, f1);
    ready_mode = 0;
    send_pair('0, VW'(4), 1'b1, cyc);
    drain();

    // R2/R3/R5: random groups under random back-pressure
    ready_mode = 1;
    for (int g = 0; g < 40; g++) begin
      int n = 1 + ($urandom % 12);
      send_group(n, $urandom & ((32'h1 << n) - 1), g[0], cyc, ff);
    end
    ready_mode = 0;
    drain();
    check(exp_q.size() == 0, "R4 all beats seen", VW'(exp_q.size()), '0);
    check(skip_count == CW'(zeros_sent), "R8 skip count", VW'(skip_count), VW'(zeros_sent));
    finish_run();
  end
endmodule